// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a synthesizable behavioural model of a single-ported synchronous cache memory with a 32-bit word and four byte lanes. Address and control are registered on the rising clock edge. A two-bit counter then walks the low address bits through a four-word burst. Read data is flow-through. The word at the registered address is driven combinationally in the same cycle, so no pipeline stage is added. The array depth is a parameter and defaults to 256 words.

A burst can begin from either of two active-low address strobes. The processor-side strobe is honoured only while the first chip enable is asserted, and it always starts a read. The controller-side strobe can start a read or a write. Each strobe is qualified by all three chip enables. After a burst has started, an advance input steps the counter. While the advance input is inactive the burst is suspended. Writes are qualified either by a global write or by a byte-write enable with per-lane bits. Output drive is gated by an asynchronous output enable and by a sleep input. The bidirectional bus is modelled as separate input data, output data and output-enable ports.

Top module: `burst_sram`

## Requirements
- R1: After reset the device is deselected: `dq_oe` stays 0 even with `oe_n` low, until a burst is started.
- R2: A burst starts only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe sampled with any enable inactive deselects the device (`dq_oe`=0).
- R3: `adsp_n` low is ignored while `ce1_n` is high. A burst in progress keeps its address, and its output data stays the same.
- R4: Flow-through read: after the edge that registers address A, `dq_out` equals word A during the following cycle, and `dq_oe`=1 when `oe_n`=0.
- R5: With `order_sel`=0 (linear), burst step k addresses low bits (s+k) mod 4, where s is the start's low two bits; the upper bits stay fixed.
- R6: With `order_sel`=1 (interleaved), step k addresses low bits s XOR k. The order is captured when the burst starts.
- R7: `adv_n`=0 on an edge advances the counter by one, and the counter wraps after four words. `adv_n`=1 holds the current address.
- R8: `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` are.
- R9: With `gw_n`=1 and `bwe_n`=0, lane i (`dq[8i+7:8i]`) is written only when `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1, nothing is written.
- R10: A cycle started by `adsp_n` never writes. A write then lands on a later edge, at the held or advanced address. A start from `adsc_n` that has write enables asserted writes at the strobed address.
- R11: `dq_oe` is 0 whenever `oe_n` is high (asynchronously), and for the cycle after an edge that wrote.
- R12: While `sleep` is high, `dq_oe` is 0 and no write or state change takes place. After wake-up the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write select, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data |
| dq_oe | output | 1 | Output drive enable |

## Verification
The first word of a read appears one edge after the address strobe, and each later word one edge after an `adv_n` edge. A write changes the readable word at the edge that takes it. The effect of `oe_n` and `sleep` on `dq_oe` needs no edge at all. Inputs are driven on the falling edge. The bench updates its reference model when it drives an edge and compares on the next falling edge, which is after exactly one register stage. The asynchronous output-enable check samples a short delay after `oe_n` changes, with no clock edge in between.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic         active;
        burst_order_e mode;
        logic [1:0]   cnt;
        logic         wrote;
    } burst_state_t;

    // low two address bits for burst step 'step' from start 'start'
    function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] step,
                                                input burst_order_e ord);
        return (ord == ORD_INTERLEAVE) ? (start ^ step) : (start + step);
    endfunction

    // per-lane write strobes from the global and byte-write controls
    function automatic logic [LANES-1:0] lane_mask(input logic gw_n,
                                                   input logic bwe_n,
                                                   input logic [LANES-1:0] bw_n);
        if (!gw_n)       return '1;
        else if (!bwe_n) return ~bw_n;
        else             return '0;
    endfunction

endpackage

// File: rtl/sram_lane.sv
module sram_lane #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // flow-through read
    assign rdata = mem[raddr];

endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              order_sel,
    input  logic              sleep,
    input  logic [LANES-1:0]  req_mask,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_mask,
    output logic              active,
    output logic              wrote
);
    burst_state_t      st;
    logic [ADDR_W-1:0] base_q;
    logic              sel, start_p, start_c, go;
    logic [1:0]        cnt_nx;

    assign sel     = !ce1_n && ce2 && !ce3_n;
    assign start_p = !adsp_n && !ce1_n;          // processor strobe needs ce1
    assign start_c = !adsc_n && !start_p;        // processor strobe wins a tie
    assign go      = start_p || start_c;
    assign cnt_nx  = st.cnt + {1'b0, !adv_n};

    assign rd_addr = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], st.cnt, st.mode)};
    assign active  = st.active;
    assign wrote   = st.wrote;

    always_comb begin
        wr_mask = '0;
        wr_addr = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], cnt_nx, st.mode)};
        if (!sleep) begin
            if (go) begin
                wr_addr = addr;
                if (start_c && sel) wr_mask = req_mask;
            end else if (st.active) begin
                wr_mask = req_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            base_q <= '0;
        end else if (sleep) begin
            st.active <= 1'b0;
            st.wrote  <= 1'b0;
        end else if (go) begin
            if (sel) begin
                st.active <= 1'b1;
                st.mode   <= burst_order_e'(order_sel);
                st.cnt    <= 2'd0;
                st.wrote  <= |wr_mask;
                base_q    <= addr;
            end else begin
                st.active <= 1'b0;
                st.wrote  <= 1'b0;
            end
        end else if (st.active) begin
            st.cnt   <= cnt_nx;
            st.wrote <= |wr_mask;
        end else begin
            st.wrote <= 1'b0;
        end
    end

    // R1: reset leaves the device deselected
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !st.active);

    // R2: a controller strobe with an inactive enable deselects
    a_r2_deselect: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !adsc_n && adsp_n && (ce1_n || !ce2 || ce3_n)) |=> !st.active);

    // R3: processor strobe is masked by ce1_n high
    a_r3_adsp_masked: assert property (@(posedge clk) disable iff (rst)
        (!sleep && ce1_n && adsc_n && st.active) |=> (st.active && $stable(base_q)));

    // R7: suspend holds the counter
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adsp_n && adsc_n && adv_n && st.active) |=> $stable(st.cnt));

    // R7: advance steps the counter by one with wrap
    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adsp_n && adsc_n && !adv_n && st.active) |=> (st.cnt == $past(st.cnt) + 2'd1));

    // R12: sleep deselects
    a_r12_sleep: assert property (@(posedge clk) disable iff (rst) sleep |=> !st.active);

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [3:0]        bw_n,
    input  logic              order_sel,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [31:0]       dq_in,
    output logic [31:0]       dq_out,
    output logic              dq_oe
);
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [LANES-1:0]  lane_we;
    logic              active, wrote;

    sram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .adsp_n    (adsp_n),
        .adsc_n    (adsc_n),
        .adv_n     (adv_n),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .order_sel (order_sel),
        .sleep     (sleep),
        .req_mask  (lane_mask(gw_n, bwe_n, bw_n)),
        .rd_addr   (rd_addr),
        .wr_addr   (wr_addr),
        .wr_mask   (lane_we),
        .active    (active),
        .wrote     (wrote)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[i]),
            .waddr (wr_addr),
            .wdata (dq_in[i*LANE_W +: LANE_W]),
            .raddr (rd_addr),
            .rdata (dq_out[i*LANE_W +: LANE_W])
        );
    end

    assign dq_oe = !oe_n && !sleep && active && !wrote;

    // R10: a processor-strobe cycle never writes
    a_r10_adsp_read: assert property (@(posedge clk) disable iff (rst)
        (!adsp_n && !ce1_n) |-> (lane_we == '0));

    // R11: outputs are released in the cycle after a write
    a_r11_write_release: assert property (@(posedge clk) disable iff (rst)
        (|lane_we) |=> !dq_oe);

endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
    localparam int AW = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic adsp_n = 1, adsc_n = 1, adv_n = 1, ce1_n = 0, ce2 = 1, ce3_n = 0;
    logic gw_n = 1, bwe_n = 1, oe_n = 0, sleep = 0, order_sel = 0;
    logic [3:0]  bw_n = 4'hF;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic        dq_oe;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    logic [31:0] ref_mem [256];
    bit          m_active = 0, m_mode = 0, m_wrote = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_cnt = '0;

    always #2 clk = ~clk;   // 250 MHz

    burst_sram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .order_sel(order_sel), .oe_n(oe_n),
        .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [1:0] offs(logic [1:0] s, logic [1:0] k, bit m);
        return m ? (s ^ k) : (s + k);
    endfunction

    function automatic logic [AW-1:0] cur_addr();
        return {m_base[AW-1:2], offs(m_base[1:0], m_cnt, m_mode)};
    endfunction

    function automatic logic [3:0] bmask();
        if (!gw_n) return 4'hF;
        if (!bwe_n) return ~bw_n;
        return 4'h0;
    endfunction

    function automatic void ref_write(logic [AW-1:0] a, logic [3:0] m);
        for (int i = 0; i < 4; i++)
            if (m[i]) ref_mem[a][i*8 +: 8] = dq_in[i*8 +: 8];
    endfunction

    // model the edge about to happen, from the requirements
    function automatic void model_edge();
        bit sel = !ce1_n && ce2 && !ce3_n;
        bit sp  = !adsp_n && !ce1_n;
        bit sc  = !adsc_n && !sp;
        logic [3:0] m = bmask();
        logic [1:0] nc;
        if (sleep) begin
            m_active = 0; m_wrote = 0;
        end else if (sp || sc) begin
            if (sel) begin
                if (sc && m != 0) ref_write(addr, m);
                m_wrote = sc && (m != 0);
                m_active = 1; m_base = addr; m_cnt = 0; m_mode = order_sel;
            end else begin
                m_active = 0; m_wrote = 0;
            end
        end else if (m_active) begin
            nc = m_cnt + {1'b0, !adv_n};
            if (m != 0) ref_write({m_base[AW-1:2], offs(m_base[1:0], nc, m_mode)}, m);
            m_cnt = nc; m_wrote = (m != 0);
        end else begin
            m_wrote = 0;
        end
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic auto_chk();
        bit exp_oe = m_active && !m_wrote && !oe_n && !sleep;
        chk("R11 dq_oe", {31'd0, dq_oe}, {31'd0, exp_oe});
        if (exp_oe) chk("R4 read data", dq_out, ref_mem[cur_addr()]);
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        auto_chk();
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; sleep = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] old;
        void'($urandom(32'h1C0FFEE5));
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: deselected after reset with oe_n low
        chk("R1 reset dq_oe", {31'd0, dq_oe}, 32'd0);

        // fill the array with controller-strobe linear write bursts
        for (int b = 0; b < 64; b++) begin
            idle(); addr = AW'(b * 4); adsc_n = 0; gw_n = 0; dq_in = $urandom;
            step();
            for (int k = 1; k < 4; k++) begin
                idle(); adv_n = 0; gw_n = 0; dq_in = $urandom;
                step();
            end
        end

        // R5/R7: processor-strobe linear burst from 0x41, then wrap
        idle(); order_sel = 0; addr = 8'h41; adsp_n = 0; step();
        chk("R5 lin step0", dq_out, ref_mem[8'h41]);
        idle(); adv_n = 0; step(); chk("R5 lin step1", dq_out, ref_mem[8'h42]);
        idle(); adv_n = 0; step(); chk("R5 lin step2", dq_out, ref_mem[8'h43]);
        idle(); adv_n = 0; step(); chk("R5 lin step3", dq_out, ref_mem[8'h40]);
        idle(); adv_n = 0; step(); chk("R7 wrap", dq_out, ref_mem[8'h41]);

        // R6: interleaved burst from 0x41; order is captured at start
        idle(); order_sel = 1; addr = 8'h41; adsp_n = 0; step();
        chk("R6 int step0", dq_out, ref_mem[8'h41]);
        order_sel = 0;
        idle(); adv_n = 0; step(); chk("R6 int step1", dq_out, ref_mem[8'h40]);
        idle(); adv_n = 0; step(); chk("R6 int step2", dq_out, ref_mem[8'h43]);
        idle(); adv_n = 0; step(); chk("R6 int step3", dq_out, ref_mem[8'h42]);

        // R7: suspend holds the address
        idle(); addr = 8'h80; adsc_n = 0; step();
        idle(); step(); chk("R7 suspend1", dq_out, ref_mem[8'h80]);
        idle(); step(); chk("R7 suspend2", dq_out, ref_mem[8'h80]);

        // R10: processor-strobe start with gw_n low does not write
        old = ref_mem[8'hA0];
        idle(); addr = 8'hA0; adsp_n = 0; gw_n = 0; dq_in = 32'hDEADBEEF; step();
        chk("R10 adsp no write oe", {31'd0, dq_oe}, 32'd1);
        chk("R10 adsp no write data", dq_out, old);

        // R9/R10: byte write on the following edge, lanes 0 and 2
        old = ref_mem[8'hA0];
        idle(); bwe_n = 0; bw_n = 4'b1010; dq_in = 32'h11223344; step();
        chk("R11 write release", {31'd0, dq_oe}, 32'd0);
        idle(); step();
        chk("R9 byte lanes", dq_out, (old & 32'hFF00FF00) | 32'h00220044);

        // R9: bwe_n high and gw_n high writes nothing even with bw_n=0
        old = ref_mem[8'hA0];
        idle(); bw_n = 4'h0; dq_in = 32'hCAFEF00D; step();
        idle(); step();
        chk("R9 no write", dq_out, old);

        // R8: gw_n overrides bwe_n high and bw_n all ones
        idle(); gw_n = 0; bwe_n = 1; bw_n = 4'hF; dq_in = 32'h5A5AA5A5; step();
        idle(); step();
        chk("R8 global write", dq_out, 32'h5A5AA5A5);

        // R3: processor strobe with ce1_n high is ignored
        idle(); addr = 8'h20; adsp_n = 0; step();
        old = ref_mem[8'h20];
        idle(); ce1_n = 1; adsp_n = 0; addr = 8'h77; step();
        chk("R3 adsp masked", dq_out, old);

        // R2: controller strobe with ce3_n high deselects
        idle(); ce3_n = 1; adsc_n = 0; addr = 8'h30; step();
        chk("R2 deselect ce3", {31'd0, dq_oe}, 32'd0);
        idle(); ce2 = 0; adsp_n = 0; addr = 8'h30; step();
        chk("R2 deselect ce2", {31'd0, dq_oe}, 32'd0);

        // R11: oe_n is asynchronous
        idle(); addr = 8'h31; adsc_n = 0; step();
        idle(); oe_n = 1; #0.5;
        chk("R11 async oe", {31'd0, dq_oe}, 32'd0);
        oe_n = 0; #0.5;
        chk("R11 async oe back", {31'd0, dq_oe}, 32'd1);

        // R12: sleep ignores writes and deselects
        idle(); ce1_n = 1; adsc_n = 0; step();
        old = ref_mem[8'h31];
        for (int i = 0; i < 3; i++) begin
            idle(); sleep = 1; adsc_n = 0; addr = 8'h31; gw_n = 0; dq_in = 32'h0BADCAFE; step();
            chk("R12 sleep oe", {31'd0, dq_oe}, 32'd0);
        end
        idle(); step();
        chk("R12 wake deselected", {31'd0, dq_oe}, 32'd0);
        idle(); addr = 8'h31; adsp_n = 0; step();
        chk("R12 no write asleep", dq_out, old);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r = $urandom;
            idle();
            addr      = AW'($urandom);
            dq_in     = $urandom;
            adsp_n    = (r[3:0] != 0);
            adsc_n    = (r[7:4] != 0);
            adv_n     = r[8];
            ce1_n     = (r[12:9] == 0);
            ce2       = (r[16:13] != 0);
            ce3_n     = (r[20:17] == 0);
            gw_n      = (r[23:21] != 0);
            bwe_n     = r[24];
            bw_n      = r[28:25];
            order_sel = r[29];
            oe_n      = (r[31:30] == 0);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule